// File: doc/BRIEF.md
# Flash Programming Command Sequencer

This block interprets a stream of 32-bit words arriving over a valid/ready port and turns it into actions on a flash subsystem. The lower 16 bits of a command word carry an opcode. A burst-write command also carries a word count in its upper 16 bits. The word after it is a start address. Each word after that becomes a memory write strobe, and the address steps by 4 for each one. A select command picks which of two flash controllers is the current target. Page-write, erase-all, lock-bit and general-purpose-bit opcodes are passed through as a one-cycle command strobe aimed at that target.

A set-security command locks the interface. After that, every word is still taken off the port, but it is discarded and flagged as an error. The only way to clear the lock is a qualified erase event. That event is a dedicated erase input held high for more than a parameterised number of clock cycles. It clears the lock and raises a one-cycle array-erase strobe. The cycle limit defaults to 220 ms at 60 MHz.

Top module: `flashCmdSeq`

## Requirements
- R1: After reset, inReady is 1, memWrEn, fwdCmdEn and arrayErase are 0, ctrlSel is 0 (controller 0), and locked and errFlag are 0.
- R2: A word is taken when inValid and inReady are both 1. In the idle state, a word whose bits 15:0 equal 0x0010 starts a burst. Its bits 31:16 give the word count, and the next word taken is the start address.
- R3: Each data word of a burst produces memWrEn=1 in the cycle after it is taken. memWrAddr is the start address plus 4 times the word's index, and memWrData is the word. After count words the sequencer returns to idle.
- R4: inReady is 0 in every cycle in which memWrEn is 1.
- R5: A burst with count 0 takes only the header and the address word. It issues no write, and the next word is decoded as a command.
- R6: Opcode 0x0020 takes one further word. A value of 0 sets ctrlSel to 0 and a value of 1 sets it to 1. Any other value sets errFlag and leaves ctrlSel unchanged.
- R7: Opcodes 0x0040 to 0x0043 give fwdCmdEn=1 for one cycle after the word is taken, with the opcode on fwdCmdOp. The command goes to the controller on ctrlSel.
- R8: Any other opcode in the idle state sets errFlag and issues no strobe. errFlag stays set until reset.
- R9: Opcode 0x0030 sets locked. While locked, every word taken sets errFlag. No memory write, forwarded command or change of ctrlSel results from it.
- R10: eraseIn held high for ERASE_CYCLES+1 consecutive clock edges clears locked and gives arrayErase=1 for exactly one cycle, both in the cycle after that edge. A shorter high pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Word on inData is offered |
| inReady | output | 1 | Sequencer can take a word this cycle |
| inData | input | DATA_W | Command, address or data word |
| eraseIn | input | 1 | Erase request level |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W | Write address |
| memWrData | output | DATA_W | Write data |
| ctrlSel | output | 1 | Current target controller |
| fwdCmdEn | output | 1 | Pass-through command strobe |
| fwdCmdOp | output | DATA_W/2 | Pass-through opcode |
| arrayErase | output | 1 | Qualified erase strobe |
| locked | output | 1 | Security lock is active |
| errFlag | output | 1 | Sticky error indication |

## Verification
The assertions assume that rstN is low for at least one edge before use and that inData is stable whenever inValid is high. They take nothing for granted about the timing of eraseIn. The bench offers a word only on a falling clock edge. It holds the word until a rising edge takes it, and then drops inValid, so no word is ever taken twice. The bench raises and lowers eraseIn only on falling edges, which keeps the count of qualifying edges exact.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;
  localparam logic [15:0] OP_BURST    = 16'h0010;
  localparam logic [15:0] OP_SELECT   = 16'h0020;
  localparam logic [15:0] OP_SECURE   = 16'h0030;
  localparam logic [15:0] OP_FWD_BASE = 16'h0040;
  localparam logic [15:0] FWD_COUNT   = 16'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SEL} seqState_t;

  typedef struct packed {
    logic loadHdr;
    logic loadAddr;
    logic issueWrite;
    logic setSel;
    logic fwdIssue;
  } seqStrobe_t;
endpackage

// File: rtl/flashEraseQual.sv
module flashEraseQual #(
  parameter int ERASE_CYCLES = 13_200_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic eraseIn,
  output logic eraseOk,
  output logic arrayErase
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 2);

  logic [CNT_W-1:0] holdCnt;

  // qualifying edge: the (ERASE_CYCLES+1)-th consecutive high sample
  assign eraseOk = eraseIn && (holdCnt == CNT_W'(ERASE_CYCLES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt    <= '0;
      arrayErase <= 1'b0;
    end else begin
      arrayErase <= eraseOk;
      if (!eraseIn)
        holdCnt <= '0;
      else if (holdCnt != CNT_W'(ERASE_CYCLES + 1))
        holdCnt <= holdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              wrBusy,
  input  logic              remZero,
  input  logic              remOne,
  input  logic              eraseOk,
  output logic              inReady,
  output seqStrobe_t        strobe,
  output logic              locked,
  output logic              errFlag
);
  localparam int HALF_W = DATA_W / 2;

  seqState_t         state, nextState;
  logic              accept, setLock, setErr, isFwd;
  logic [HALF_W-1:0] opField;

  assign inReady = !wrBusy;
  assign accept  = inValid && inReady;
  assign opField = inData[HALF_W-1:0];
  assign isFwd   = (opField >= HALF_W'(OP_FWD_BASE)) &&
                   (opField <  HALF_W'(OP_FWD_BASE + FWD_COUNT));

  always_comb begin
    strobe    = '0;
    nextState = state;
    setLock   = 1'b0;
    setErr    = 1'b0;
    if (accept) begin
      if (locked) begin
        setErr = 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (opField == HALF_W'(OP_BURST)) begin
              strobe.loadHdr = 1'b1;
              nextState      = ST_ADDR;
            end else if (opField == HALF_W'(OP_SELECT)) begin
              nextState = ST_SEL;
            end else if (opField == HALF_W'(OP_SECURE)) begin
              setLock = 1'b1;
            end else if (isFwd) begin
              strobe.fwdIssue = 1'b1;
            end else begin
              setErr = 1'b1;
            end
          end
          ST_ADDR: begin
            strobe.loadAddr = 1'b1;
            nextState       = remZero ? ST_IDLE : ST_DATA;
          end
          ST_DATA: begin
            strobe.issueWrite = 1'b1;
            if (remOne) nextState = ST_IDLE;
          end
          ST_SEL: begin
            if (inData < DATA_W'(2)) strobe.setSel = 1'b1;
            else                     setErr        = 1'b1;
            nextState = ST_IDLE;
          end
          default: nextState = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      locked  <= 1'b0;
      errFlag <= 1'b0;
    end else if (eraseOk) begin
      state  <= ST_IDLE;
      locked <= 1'b0;
    end else begin
      state <= nextState;
      if (setLock) locked  <= 1'b1;
      if (setErr)  errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DATA_W-1:0]      inData,
  input  seqStrobe_t             strobe,
  output logic                   remZero,
  output logic                   remOne,
  output logic                   memWrEn,
  output logic [ADDR_W-1:0]      memWrAddr,
  output logic [DATA_W-1:0]      memWrData,
  output logic                   ctrlSel,
  output logic                   fwdCmdEn,
  output logic [DATA_W/2-1:0]    fwdCmdOp
);
  localparam int HALF_W = DATA_W / 2;
  localparam int STEP   = DATA_W / 8;

  logic [HALF_W-1:0] remCnt;
  logic [ADDR_W-1:0] nextAddr;

  assign remZero = (remCnt == '0);
  assign remOne  = (remCnt == HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCnt    <= '0;
      nextAddr  <= '0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
      ctrlSel   <= 1'b0;
      fwdCmdEn  <= 1'b0;
      fwdCmdOp  <= '0;
    end else begin
      memWrEn  <= strobe.issueWrite;
      fwdCmdEn <= strobe.fwdIssue;
      if (strobe.loadHdr)  remCnt   <= inData[DATA_W-1:HALF_W];
      if (strobe.loadAddr) nextAddr <= inData[ADDR_W-1:0];
      if (strobe.issueWrite) begin
        remCnt    <= remCnt - 1'b1;
        nextAddr  <= nextAddr + ADDR_W'(STEP);
        memWrAddr <= nextAddr;
        memWrData <= inData;
      end
      if (strobe.setSel)   ctrlSel  <= inData[0];
      if (strobe.fwdIssue) fwdCmdOp <= inData[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/flashCmdSeq.sv
module flashCmdSeq
  import flashSeqPkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int ERASE_CYCLES = 13_200_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [DATA_W-1:0]   inData,
  input  logic                eraseIn,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic                ctrlSel,
  output logic                fwdCmdEn,
  output logic [DATA_W/2-1:0] fwdCmdOp,
  output logic                arrayErase,
  output logic                locked,
  output logic                errFlag
);
  seqStrobe_t strobe;
  logic       remZero, remOne, eraseOk;

  flashEraseQual #(.ERASE_CYCLES(ERASE_CYCLES)) u_erase (
    .clk(clk), .rstN(rstN), .eraseIn(eraseIn),
    .eraseOk(eraseOk), .arrayErase(arrayErase)
  );

  flashSeqCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .wrBusy(memWrEn), .remZero(remZero), .remOne(remOne),
    .eraseOk(eraseOk), .inReady(inReady), .strobe(strobe),
    .locked(locked), .errFlag(errFlag)
  );

  flashSeqData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe),
    .remZero(remZero), .remOne(remOne), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .ctrlSel(ctrlSel),
    .fwdCmdEn(fwdCmdEn), .fwdCmdOp(fwdCmdOp)
  );
endmodule

// File: rtl/flashCmdSeqChk.sv
module flashCmdSeqChk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic memWrEn,
  input logic ctrlSel,
  input logic fwdCmdEn,
  input logic arrayErase,
  input logic locked,
  input logic errFlag
);
  // R4
  ready_low_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !inReady);

  // R3
  write_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(inValid && inReady));

  // R7
  fwd_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdCmdEn |-> $past(inValid && inReady));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (!memWrEn && !fwdCmdEn && $stable(ctrlSel)));

  // R10
  unlock_needs_erase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> arrayErase);

  // R10
  erase_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrayErase |=> !arrayErase);
endmodule

bind flashCmdSeq flashCmdSeqChk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .memWrEn(memWrEn), .ctrlSel(ctrlSel), .fwdCmdEn(fwdCmdEn),
  .arrayErase(arrayErase), .locked(locked), .errFlag(errFlag)
);

// File: tb/tb_flashCmdSeq.sv
module tb_flashCmdSeq;
  localparam int E  = 8;
  localparam int NV = 12;

  // burst of 3, select 1, zero-count burst, burst of 1
  localparam logic [31:0] VW [NV] = '{
    32'h0003_0010, 32'h0000_1000, 32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003,
    32'h0000_0020, 32'h0000_0001,
    32'h0000_0010, 32'h0000_2000,
    32'h0001_0010, 32'h0000_3000, 32'h0000_0055};
  localparam logic VE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                               1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] VA [NV] = '{
    32'h0, 32'h0, 32'h1000, 32'h1004, 32'h1008, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h3000};
  localparam logic VS [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                               1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        eraseIn = 1'b0;
  logic        inReady, memWrEn, ctrlSel, fwdCmdEn, arrayErase, locked, errFlag;
  logic [31:0] memWrAddr, memWrData;
  logic [15:0] fwdCmdOp;
  int          checks = 0;
  int          errors = 0;
  int          eraseSeen = 0;

  always #5 clk = ~clk;

  flashCmdSeq #(.DATA_W(32), .ADDR_W(32), .ERASE_CYCLES(E)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .eraseIn(eraseIn), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .ctrlSel(ctrlSel),
    .fwdCmdEn(fwdCmdEn), .fwdCmdOp(fwdCmdOp), .arrayErase(arrayErase),
    .locked(locked), .errFlag(errFlag)
  );

  always @(negedge clk) if (arrayErase === 1'b1) eraseSeen++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inData  = w;
    while (inReady !== 1'b1) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; eraseIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkIdle();
    check(inReady === 1'b1, "R1", "inReady", {31'b0, inReady}, 32'h1);
    check(memWrEn === 1'b0, "R1", "memWrEn", {31'b0, memWrEn}, 32'h0);
    check(fwdCmdEn === 1'b0, "R1", "fwdCmdEn", {31'b0, fwdCmdEn}, 32'h0);
    check(ctrlSel === 1'b0, "R1", "ctrlSel", {31'b0, ctrlSel}, 32'h0);
    check(locked === 1'b0, "R1", "locked", {31'b0, locked}, 32'h0);
    check(errFlag === 1'b0, "R1", "errFlag", {31'b0, errFlag}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    checkIdle();

    // R2 R3 R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      sendWord(VW[i]);
      check(memWrEn === VE[i], "R2 R3 R5", $sformatf("row %0d memWrEn", i),
            {31'b0, memWrEn}, {31'b0, VE[i]});
      if (VE[i]) begin
        check(memWrAddr === VA[i], "R3", $sformatf("row %0d addr", i), memWrAddr, VA[i]);
        check(memWrData === VW[i], "R3", $sformatf("row %0d data", i), memWrData, VW[i]);
        check(inReady === 1'b0, "R4", $sformatf("row %0d inReady", i),
              {31'b0, inReady}, 32'h0);
      end
      check(ctrlSel === VS[i], "R6", $sformatf("row %0d ctrlSel", i),
            {31'b0, ctrlSel}, {31'b0, VS[i]});
    end
    check(errFlag === 1'b0, "R2", "no error after table", {31'b0, errFlag}, 32'h0);

    // R7: pass-through opcode
    sendWord(32'h0000_0042);
    check(fwdCmdEn === 1'b1, "R7", "fwdCmdEn", {31'b0, fwdCmdEn}, 32'h1);
    check(fwdCmdOp === 16'h0042, "R7", "fwdCmdOp", {16'b0, fwdCmdOp}, 32'h42);
    @(negedge clk);
    check(fwdCmdEn === 1'b0, "R7", "fwdCmdEn one cycle", {31'b0, fwdCmdEn}, 32'h0);

    // R6: bad select value
    sendWord(32'h0000_0020);
    sendWord(32'h0000_0005);
    check(errFlag === 1'b1, "R6", "errFlag on bad select", {31'b0, errFlag}, 32'h1);
    check(ctrlSel === 1'b1, "R6", "ctrlSel unchanged", {31'b0, ctrlSel}, 32'h1);

    // R8: unknown opcode
    doReset();
    @(negedge clk);
    checkIdle();
    sendWord(32'h0000_00FF);
    check(errFlag === 1'b1, "R8", "errFlag", {31'b0, errFlag}, 32'h1);
    check(memWrEn === 1'b0 && fwdCmdEn === 1'b0, "R8", "no strobe",
          {30'b0, memWrEn, fwdCmdEn}, 32'h0);
    sendWord(32'h0000_0042);
    check(errFlag === 1'b1, "R8", "errFlag sticky", {31'b0, errFlag}, 32'h1);

    // R9: lock
    doReset();
    sendWord(32'h0000_0030);
    check(locked === 1'b1, "R9", "locked", {31'b0, locked}, 32'h1);
    check(errFlag === 1'b0, "R9", "secure is not an error", {31'b0, errFlag}, 32'h0);
    sendWord(32'h0001_0010);
    sendWord(32'h0000_4000);
    sendWord(32'h0000_0077);
    check(memWrEn === 1'b0, "R9", "no write while locked", {31'b0, memWrEn}, 32'h0);
    check(errFlag === 1'b1, "R9", "errFlag while locked", {31'b0, errFlag}, 32'h1);
    sendWord(32'h0000_0020);
    sendWord(32'h0000_0001);
    check(ctrlSel === 1'b0, "R9", "select ignored", {31'b0, ctrlSel}, 32'h0);
    sendWord(32'h0000_0041);
    check(fwdCmdEn === 1'b0, "R9", "no forward", {31'b0, fwdCmdEn}, 32'h0);

    // R10: short pulse ignored
    @(negedge clk);
    eraseIn = 1'b1;
    repeat (E) @(negedge clk);
    eraseIn = 1'b0;
    repeat (2) @(negedge clk);
    check(locked === 1'b1, "R10", "short pulse keeps lock", {31'b0, locked}, 32'h1);
    check(eraseSeen == 0, "R10", "no erase on short pulse", eraseSeen, 32'h0);

    // R10: long pulse
    eraseIn = 1'b1;
    repeat (E + 1) @(negedge clk);
    check(arrayErase === 1'b1, "R10", "arrayErase", {31'b0, arrayErase}, 32'h1);
    check(locked === 1'b0, "R10", "lock cleared", {31'b0, locked}, 32'h0);
    repeat (3) @(negedge clk);
    eraseIn = 1'b0;
    check(eraseSeen == 1, "R10", "single erase pulse", eraseSeen, 32'h1);

    // R3: writes work again after unlock
    sendWord(32'h0001_0010);
    sendWord(32'h0000_5000);
    sendWord(32'h0000_0099);
    check(memWrEn === 1'b1, "R3", "write after unlock", {31'b0, memWrEn}, 32'h1);
    check(memWrAddr === 32'h5000, "R3", "addr after unlock", memWrAddr, 32'h5000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule